// File: doc/BRIEF.md
# History Reset Request Controller

This block carries out the privileged "clear prediction history" operation of a processor core. When a request strobe arrives it captures a 32-bit selection mask, the current privilege level and three mode flags. The flags say whether the feature is present, whether the core is in virtual-8086 mode, and whether it is inside a transactional region. The block runs a fixed-priority series of legality checks. If every check passes, each history structure whose mask bit is set receives a one-cycle clear pulse. Examples of such structures are the branch target buffer, the TLB and other predictor arrays.

Software chooses which structures may be cleared through an enable register. A write to that register keeps only the bits present in a hardwired capability mask. Every accepted request completes exactly one cycle later with a done strobe and a 2-bit outcome code. A successful request holds a busy output high during its completion cycle. Requests presented while busy is high are dropped. An 8-bit immediate travels with each request and has no effect on the result.

Top module: `hist_clear_unit`

## Requirements
- R1: After reset, doneValid, busy and histClear are all 0 and the enable register reads back as 0.
- R2: A write to the enable register stores cfgWrData AND CAP_MASK. Bits clear in CAP_MASK always read back as 0.
- R3: A request is accepted when reqValid is 1 and busy is 0. An accepted request gives doneValid=1 in the next cycle and in no other cycle. With no accepted request, doneValid stays 0.
- R4: For an outcome of ok (code 0), histClear equals the request mask for the single done cycle and is 0 in every other cycle. An all-zero mask therefore completes as ok with no pulses.
- R5: When featOn is 0 the outcome is undefined-opcode (code 1), whatever the other inputs are.
- R6: When featOn is 1 and v86Mode is 1 the outcome is general-protection (code 2).
- R7: When featOn is 1, v86Mode is 0 and inTxn is 1 the outcome is transaction abort (code 3).
- R8: When none of the above applies and privLevel is not 0, the outcome is general-protection (code 2).
- R9: When none of the above applies and (reqMask AND NOT enable) is nonzero, the outcome is general-protection (code 2). Otherwise the outcome is ok.
- R10: A request whose outcome is not ok drives no clear pulse.
- R11: busy is 1 exactly in the done cycle of an ok outcome. A request presented in that cycle is ignored and produces no done strobe.
- R12: The value of reqImm has no effect on the outcome code, the pulses or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqMask | input | MASK_W | Selection of history structures to clear |
| reqImm | input | 8 | Immediate carried with the request, ignored |
| privLevel | input | 2 | Current privilege level |
| featOn | input | 1 | Feature present |
| v86Mode | input | 1 | Core is in virtual-8086 mode |
| inTxn | input | 1 | Core is inside a transactional region |
| cfgWrEn | input | 1 | Enable register write strobe |
| cfgWrData | input | MASK_W | Enable register write data |
| cfgRdData | output | MASK_W | Enable register contents |
| busy | output | 1 | Serialising; new requests are dropped |
| doneValid | output | 1 | Completion strobe |
| doneCode | output | 2 | Outcome: 0 ok, 1 undefined-opcode, 2 general-protection, 3 abort |
| histClear | output | MASK_W | One-cycle clear pulse per history structure |

## Verification
The assertions check the following on every cycle:
- the one-cycle completion timing;
- that pulses appear only with an ok outcome and match the captured mask;
- that busy coincides with ok completions;
- that the enable register never holds a bit outside the capability mask;
- the outcome for two points in the priority chain, feature absent and mask-versus-enable.

Only the bench scenarios show the full priority order across combined faults. They also show that a request dropped while busy leaves no trace, and that the immediate is ignored, by comparing requests that differ only in reqImm.

// File: rtl/hist_clear_pkg.sv
package hist_clear_pkg;

  typedef enum logic [1:0] {
    OUT_OK    = 2'd0,
    OUT_UD    = 2'd1,
    OUT_GP    = 2'd2,
    OUT_ABORT = 2'd3
  } outcome_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEnable;  // commit a filtered enable-register write
    logic fire;      // launch clear pulses for the captured mask
  } ctlStrobe_t;

endpackage

// File: rtl/hist_clear_dp.sv
module hist_clear_dp
  import hist_clear_pkg::*;
#(
  parameter int unsigned MASK_W = 32,
  parameter logic [MASK_W-1:0] CAP_MASK = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [MASK_W-1:0] reqMask,
  input  logic [MASK_W-1:0] cfgWrData,
  output logic [MASK_W-1:0] enableReg,
  output logic              maskViol,
  output logic [MASK_W-1:0] histClear
);

  logic [MASK_W-1:0] illegalBits;

  // request bits that software has not enabled
  assign illegalBits = reqMask & ~enableReg;
  assign maskViol    = |illegalBits;

  // enable register: unimplemented bits are filtered on write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableReg <= '0;
    end else if (strobe.wrEnable) begin
      enableReg <= cfgWrData & CAP_MASK;
    end
  end

  // one flop per history structure; a pulse lasts exactly one cycle
  for (genvar i = 0; i < MASK_W; i++) begin : g_pulse
    always_ff @(posedge clk) begin
      if (!rstN) begin
        histClear[i] <= 1'b0;
      end else begin
        histClear[i] <= strobe.fire & reqMask[i];
      end
    end
  end

endmodule

// File: rtl/hist_clear_ctl.sv
module hist_clear_ctl
  import hist_clear_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] privLevel,
  input  logic       featOn,
  input  logic       v86Mode,
  input  logic       inTxn,
  input  logic       maskViol,
  input  logic       cfgWrEn,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       doneValid,
  output logic [1:0] doneCode
);

  logic     accept;
  outcome_e verdict;

  assign accept = reqValid & ~busy;

  // fixed check priority, first match wins
  always_comb begin
    if (!featOn)                verdict = OUT_UD;
    else if (v86Mode)           verdict = OUT_GP;
    else if (inTxn)             verdict = OUT_ABORT;
    else if (privLevel != 2'd0) verdict = OUT_GP;
    else if (maskViol)          verdict = OUT_GP;
    else                        verdict = OUT_OK;
  end

  always_comb begin
    strobe.wrEnable = cfgWrEn;
    strobe.fire     = accept & (verdict == OUT_OK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneCode  <= OUT_OK;
      busy      <= 1'b0;
    end else begin
      doneValid <= accept;
      doneCode  <= accept ? verdict : OUT_OK;
      busy      <= accept & (verdict == OUT_OK);
    end
  end

endmodule

// File: rtl/hist_clear_unit.sv
module hist_clear_unit
  import hist_clear_pkg::*;
#(
  parameter int unsigned MASK_W = 32,
  parameter logic [MASK_W-1:0] CAP_MASK = 32'h0000_F0FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [MASK_W-1:0] reqMask,
  input  logic [7:0]        reqImm,
  input  logic [1:0]        privLevel,
  input  logic              featOn,
  input  logic              v86Mode,
  input  logic              inTxn,
  input  logic              cfgWrEn,
  input  logic [MASK_W-1:0] cfgWrData,
  output logic [MASK_W-1:0] cfgRdData,
  output logic              busy,
  output logic              doneValid,
  output logic [1:0]        doneCode,
  output logic [MASK_W-1:0] histClear
);

  ctlStrobe_t strobe;
  logic       maskViol;
  logic [7:0] immUnused;

  // the immediate is architecturally ignored
  assign immUnused = reqImm;

  hist_clear_ctl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .privLevel (privLevel),
    .featOn    (featOn),
    .v86Mode   (v86Mode),
    .inTxn     (inTxn),
    .maskViol  (maskViol),
    .cfgWrEn   (cfgWrEn),
    .strobe    (strobe),
    .busy      (busy),
    .doneValid (doneValid),
    .doneCode  (doneCode)
  );

  hist_clear_dp #(
    .MASK_W   (MASK_W),
    .CAP_MASK (CAP_MASK)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqMask   (reqMask),
    .cfgWrData (cfgWrData),
    .enableReg (cfgRdData),
    .maskViol  (maskViol),
    .histClear (histClear)
  );

endmodule

// File: rtl/hist_clear_chk.sv
module hist_clear_chk #(
  parameter int unsigned MASK_W = 32,
  parameter logic [MASK_W-1:0] CAP_MASK = '1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [MASK_W-1:0] reqMask,
  input logic [1:0]        privLevel,
  input logic              featOn,
  input logic              v86Mode,
  input logic              inTxn,
  input logic [MASK_W-1:0] cfgRdData,
  input logic              busy,
  input logic              doneValid,
  input logic [1:0]        doneCode,
  input logic [MASK_W-1:0] histClear
);

  logic acc;
  assign acc = reqValid & ~busy;

  assert_done_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> doneValid);

  assert_no_spurious_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    !acc |=> !doneValid);

  assert_pulse_only_ok_R10: assert property (@(posedge clk) disable iff (!rstN)
    (histClear != '0) |-> (doneValid && doneCode == 2'd0));

  assert_pulse_matches_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> (!(doneValid && doneCode == 2'd0) || histClear == $past(reqMask)));

  assert_busy_ok_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (doneValid && doneCode == 2'd0));

  assert_ok_sets_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneCode == 2'd0) |-> busy);

  assert_cap_filter_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData & ~CAP_MASK) == '0);

  assert_ud_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !featOn) |=> doneCode == 2'd1);

  assert_mask_gp_R9: assert property (@(posedge clk) disable iff (!rstN)
    (acc && featOn && !v86Mode && !inTxn && privLevel == 2'd0 &&
     (reqMask & ~cfgRdData) != '0) |=> doneCode == 2'd2);

endmodule

bind hist_clear_unit hist_clear_chk #(
  .MASK_W   (MASK_W),
  .CAP_MASK (CAP_MASK)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqMask   (reqMask),
  .privLevel (privLevel),
  .featOn    (featOn),
  .v86Mode   (v86Mode),
  .inTxn     (inTxn),
  .cfgRdData (cfgRdData),
  .busy      (busy),
  .doneValid (doneValid),
  .doneCode  (doneCode),
  .histClear (histClear)
);

// File: tb/sim_hist_clear_unit.sv
`timescale 1ns/1ps
module sim_hist_clear_unit;

  localparam int unsigned MW = 32;
  localparam logic [MW-1:0] CAP = 32'h0000_F0FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [MW-1:0] reqMask = '0;
  logic [7:0] reqImm = '0;
  logic [1:0] privLevel = '0;
  logic featOn = 1'b1, v86Mode = 1'b0, inTxn = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [MW-1:0] cfgWrData = '0;
  logic [MW-1:0] cfgRdData;
  logic busy, doneValid;
  logic [1:0] doneCode;
  logic [MW-1:0] histClear;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [MW-1:0] enModel = '0;

  always #5 clk = ~clk;

  hist_clear_unit #(.MASK_W(MW), .CAP_MASK(CAP)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMask(reqMask),
    .reqImm(reqImm), .privLevel(privLevel), .featOn(featOn),
    .v86Mode(v86Mode), .inTxn(inTxn), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .busy(busy),
    .doneValid(doneValid), .doneCode(doneCode), .histClear(histClear)
  );

  function automatic logic [1:0] expCode(logic f, logic v, logic t,
                                         logic [1:0] p, logic [MW-1:0] m,
                                         logic [MW-1:0] en);
    if (!f) return 2'd1;
    if (v) return 2'd2;
    if (t) return 2'd3;
    if (p != 2'd0) return 2'd2;
    if ((m & ~en) != '0) return 2'd2;
    return 2'd0;
  endfunction

  function automatic string codeTag(logic [1:0] c, logic f, logic v,
                                    logic t, logic [1:0] p);
    if (!f) return "R5";
    if (v) return "R6";
    if (t) return "R7";
    if (p != 2'd0) return "R8";
    return "R9";
  endfunction

  task automatic chk(string tag, logic [MW-1:0] act, logic [MW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrEnable(logic [MW-1:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    enModel = d & CAP;
    chk("R2 enable readback", cfgRdData, enModel);
  endtask

  task automatic doReq(logic [MW-1:0] m, logic [7:0] imm, logic [1:0] p,
                       logic f, logic v, logic t, bit retry);
    logic [1:0] ec;
    ec = expCode(f, v, t, p, m, enModel);
    @(negedge clk);
    reqValid = 1'b1; reqMask = m; reqImm = imm;
    privLevel = p; featOn = f; v86Mode = v; inTxn = t;
    @(negedge clk);
    chk("R3 doneValid in done cycle", {31'd0, doneValid}, 1);
    chk({codeTag(ec, f, v, t, p), " R12 outcome code"}, {30'd0, doneCode}, {30'd0, ec});
    chk(ec == 2'd0 ? "R4 pulses" : "R10 no pulses", histClear, ec == 2'd0 ? m : '0);
    chk("R11 busy in done cycle", {31'd0, busy}, {31'd0, ec == 2'd0});
    if (retry && ec == 2'd0) begin
      // legal request offered while busy: must be dropped
      reqMask = enModel; featOn = 1'b1; v86Mode = 1'b0; inTxn = 1'b0; privLevel = 2'd0;
    end else begin
      reqValid = 1'b0;
    end
    @(negedge clk);
    reqValid = 1'b0;
    chk("R3 R11 no done after done cycle", {31'd0, doneValid}, 0);
    chk("R4 pulse is one cycle", histClear, '0);
    chk("R11 busy dropped", {31'd0, busy}, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 doneValid after reset", {31'd0, doneValid}, 0);
    chk("R1 busy after reset", {31'd0, busy}, 0);
    chk("R1 histClear after reset", histClear, '0);
    chk("R1 enable after reset", cfgRdData, '0);

    // directed corners
    doReq(32'h1, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 0);       // R9 not enabled
    wrEnable(32'hFFFF_FFFF);                               // R2 filter
    wrEnable(32'h0000_00F3);
    doReq(32'h0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 0);       // R4 zero mask no-op
    doReq(32'h0000_0003, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 1); // R4 + R11 retry
    doReq(32'h0000_0003, 8'hFF, 2'd0, 1'b1, 1'b0, 1'b0, 0); // R12 imm differs
    doReq(32'h0000_0003, 8'h5A, 2'd0, 1'b0, 1'b1, 1'b1, 0); // R5 beats all
    doReq(32'h0000_0003, 8'h00, 2'd3, 1'b1, 1'b1, 1'b1, 0); // R6 beats abort
    doReq(32'h0000_0003, 8'h00, 2'd3, 1'b1, 1'b0, 1'b1, 0); // R7 beats priv
    doReq(32'h0000_0003, 8'h00, 2'd3, 1'b1, 1'b0, 1'b0, 0); // R8
    doReq(32'h0000_0004, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 0); // R9
    doReq(32'h0000_0000, 8'h00, 2'd1, 1'b1, 1'b0, 1'b0, 0); // R8 zero mask

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [MW-1:0] m;
      if ($urandom_range(0, 19) == 0) wrEnable($urandom);
      m = ($urandom_range(0, 3) == 0) ? $urandom : ($urandom & enModel);
      doReq(m, 8'($urandom),
            ($urandom_range(0, 5) == 0) ? 2'($urandom_range(1, 3)) : 2'd0,
            $urandom_range(0, 9) != 0,
            $urandom_range(0, 9) == 0,
            $urandom_range(0, 9) == 0,
            $urandom_range(0, 1) == 1);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule